// File: doc/BRIEF.md
# Partial-Write Read-Modify-Write Engine for ECC Memory

This block accepts byte-masked write requests from a bus and applies them to a single-port SRAM whose 32-bit words each carry 7 SEC-DED check bits. Because the check bits cover the whole word, a request that enables fewer than all four bytes is turned into a sequence: fetch the stored codeword, decode and repair it, splice the enabled request bytes over it, encode the result and store the complete codeword. A narrow write therefore also scrubs a single-bit fault sitting in the bytes it leaves untouched.

A request that enables all four bytes needs no old data and goes straight to encoding and storing. Each request is taken with a valid/ready handshake and finished with a one-cycle acknowledge pulse that carries two status flags: a repaired single-bit fault and an unrepairable double-bit fault in the fetched word. Requests are refused until the memory reports that its contents hold valid check bits.

Top module: `subword_rmw`

## Requirements
- R1: While `init_done` is low, `req_ready` stays low and the memory port is never enabled; after reset, `req_ready`, `ack` and `mem_en` are all low.
- R2: A request with `req_be` not equal to 4'b1111 causes exactly one memory read of `req_addr` followed by exactly one memory write of the same address; a request with all four enables set causes one write and no read.
- R3: The stored data equals the request byte for every lane whose enable is set (lane k is data bits 8k+7..8k) and the repaired old byte for every other lane.
- R4: The stored codeword `{chk[6:0], data[31:0]}` is a valid SEC-DED word: data bit i sits at the i-th position, counting from zero, among the Hamming positions 3..38 that are not powers of two, check bit j (j < 6) sits at position 2^j, and the XOR of the positions of all set bits is zero; check bit 6 makes the parity over all 39 bits even.
- R5: A single flipped bit anywhere in the 39-bit stored word is repaired before merging, and the acknowledge carries `ack_corrected` = 1, `ack_uncorrectable` = 0.
- R6: Two flipped bits in the fetched word do not stop the write: the untouched lanes are stored as read (unrepaired), the new word is freshly encoded, and the acknowledge carries `ack_uncorrectable` = 1, `ack_corrected` = 0.
- R7: `ack` is a one-cycle pulse that appears 3 clock edges after the accepting edge for a partial write and 2 edges after it for a full-word write; both flags are 0 for full-word writes and whenever `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Memory holds valid check bits; requests allowed |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | ADDR_W | Word address |
| req_be | input | 4 | Byte lane enables |
| req_wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| ack_corrected | output | 1 | Single-bit fault repaired in fetched word |
| ack_uncorrectable | output | 1 | Double-bit fault found in fetched word |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (high) or read (low) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 39 | Codeword to store |
| mem_rdata | input | 39 | Codeword returned one cycle after a read |

## Verification
The assertions assume that `init_done` never falls once it has risen after reset, that the memory returns read data on the cycle after the read, and that request fields stay put while `req_valid` waits for `req_ready`. The bench raises `init_done` once and keeps it high, models the memory with exactly one cycle of read latency, and drives request fields only away from the clock edge while the block is idle. Faults are injected straight into the memory model only between requests, so every fetched word is either clean, one flip away or two flips away from a valid codeword.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = DATA_W / BYTE_W;
    localparam int HAM_W     = 6;
    localparam int CHK_W     = HAM_W + 1;
    localparam int CODE_W    = DATA_W + CHK_W;
    localparam int POS_LIMIT = 1 << HAM_W;

    typedef logic [DATA_W-1:0]    data_t;
    typedef logic [CHK_W-1:0]     chk_t;
    typedef logic [NUM_BYTES-1:0] be_t;

    typedef struct packed {
        chk_t  chk;
        data_t data;
    } code_t;

    typedef struct packed {
        logic corrected;
        logic uncorrectable;
    } fault_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MERGE,
        ST_ENCODE,
        ST_WRITE
    } state_e;

    // Hamming position of data bit idx: the idx-th non-power-of-two from 3 up.
    function automatic int data_pos(input int idx);
        int n;
        n = 0;
        for (int q = 3; q < POS_LIMIT; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (n == idx) return q;
                n++;
            end
        end
        return 0;
    endfunction

    // XOR of the positions of all set data bits.
    function automatic logic [HAM_W-1:0] ham_bits(input data_t d);
        logic [HAM_W-1:0] r;
        int p;
        r = '0;
        for (int i = 0; i < DATA_W; i++) begin
            p = data_pos(i);
            if (d[i]) r = r ^ p[HAM_W-1:0];
        end
        return r;
    endfunction

    function automatic code_t encode(input data_t d);
        code_t c;
        c.data = d;
        c.chk[HAM_W-1:0] = ham_bits(d);
        c.chk[HAM_W] = ^{d, c.chk[HAM_W-1:0]};
        return c;
    endfunction

endpackage

// File: rtl/rmw_secded_dec.sv
module rmw_secded_dec
    import rmw_pkg::*;
(
    input  code_t  code_i,
    output data_t  data_o,
    output fault_t fault_o
);
    logic [HAM_W-1:0] syndrome;
    logic             odd_parity;

    always_comb begin
        syndrome   = ham_bits(code_i.data) ^ code_i.chk[HAM_W-1:0];
        odd_parity = ^code_i;
        data_o     = code_i.data;
        fault_o    = '0;
        if (odd_parity) begin
            fault_o.corrected = 1'b1;
            for (int i = 0; i < DATA_W; i++) begin
                if (data_pos(i) == int'(syndrome)) data_o[i] = ~code_i.data[i];
            end
        end else if (syndrome != '0) begin
            fault_o.uncorrectable = 1'b1;
        end
    end
endmodule

// File: rtl/rmw_byte_merge.sv
module rmw_byte_merge
    import rmw_pkg::*;
(
    input  data_t old_i,
    input  data_t new_i,
    input  be_t   be_i,
    output data_t merged_o
);
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        assign merged_o[b*BYTE_W +: BYTE_W] =
            be_i[b] ? new_i[b*BYTE_W +: BYTE_W] : old_i[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/rmw_secded_enc.sv
module rmw_secded_enc
    import rmw_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);
    assign code_o = encode(data_i);
endmodule

// File: rtl/subword_rmw.sv
module subword_rmw
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_done,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NUM_BYTES-1:0] req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic              ack_corrected,
    output logic              ack_uncorrectable,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CODE_W-1:0] mem_wdata,
    input  logic [CODE_W-1:0] mem_rdata
);
    localparam be_t FULL_BE = '1;

    state_e            state_q;
    logic [ADDR_W-1:0] addr_q;
    be_t               be_q;
    data_t             wdata_q;
    code_t             wr_code_q;
    fault_t            fault_q;
    logic              ack_q;
    fault_t            ack_fault_q;

    data_t  repaired;
    fault_t rd_fault;
    data_t  merged;
    data_t  enc_src;
    code_t  enc_code;
    logic   accept;

    rmw_secded_dec u_dec (
        .code_i  (code_t'(mem_rdata)),
        .data_o  (repaired),
        .fault_o (rd_fault)
    );

    rmw_byte_merge u_merge (
        .old_i    (repaired),
        .new_i    (wdata_q),
        .be_i     (be_q),
        .merged_o (merged)
    );

    assign enc_src = (state_q == ST_MERGE) ? merged : wdata_q;

    rmw_secded_enc u_enc (
        .data_i (enc_src),
        .code_o (enc_code)
    );

    assign req_ready = (state_q == ST_IDLE) && init_done;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            be_q        <= '0;
            wdata_q     <= '0;
            wr_code_q   <= '0;
            fault_q     <= '0;
            ack_q       <= 1'b0;
            ack_fault_q <= '0;
        end else begin
            ack_q       <= 1'b0;
            ack_fault_q <= '0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        addr_q  <= req_addr;
                        be_q    <= req_be;
                        wdata_q <= req_wdata;
                        state_q <= (req_be == FULL_BE) ? ST_ENCODE : ST_READ;
                    end
                end
                ST_READ: begin
                    state_q <= ST_MERGE;
                end
                ST_MERGE: begin
                    wr_code_q <= enc_code;
                    fault_q   <= rd_fault;
                    state_q   <= ST_WRITE;
                end
                ST_ENCODE: begin
                    wr_code_q <= enc_code;
                    fault_q   <= '0;
                    state_q   <= ST_WRITE;
                end
                ST_WRITE: begin
                    ack_q       <= 1'b1;
                    ack_fault_q <= fault_q;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_en            = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we            = (state_q == ST_WRITE);
    assign mem_addr          = addr_q;
    assign mem_wdata         = wr_code_q;
    assign ack               = ack_q;
    assign ack_corrected     = ack_fault_q.corrected;
    assign ack_uncorrectable = ack_fault_q.uncorrectable;

endmodule

// File: rtl/subword_rmw_checker.sv
module subword_rmw_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              init_done,
    input logic              req_ready,
    input logic              ack,
    input logic              ack_corrected,
    input logic              ack_uncorrectable,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    a_r1_no_access_before_init: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !mem_en);

    a_r1_ready_needs_init: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> init_done);

    a_r2_read_then_write_same_addr: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> ##1 (mem_en && mem_we && mem_addr == $past(mem_addr, 2)));

    a_r2_idle_no_access: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_en);

    a_r7_ack_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    a_r7_ack_after_write: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(mem_en && mem_we));

    a_r7_flags_need_ack: assert property (@(posedge clk) disable iff (rst)
        (ack_corrected || ack_uncorrectable) |-> ack);

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ack_corrected && ack_uncorrectable));
endmodule

bind subword_rmw subword_rmw_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk               (clk),
    .rst               (rst),
    .init_done         (init_done),
    .req_ready         (req_ready),
    .ack               (ack),
    .ack_corrected     (ack_corrected),
    .ack_uncorrectable (ack_uncorrectable),
    .mem_en            (mem_en),
    .mem_we            (mem_we),
    .mem_addr          (mem_addr)
);

// File: tb/subword_rmw_tb_top.sv
module subword_rmw_tb_top;
    import rmw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int DEPTH      = 1 << AW;

    logic              clk = 1'b0;
    logic              rst;
    logic              init_done;
    logic              req_valid;
    logic              req_ready;
    logic [AW-1:0]     req_addr;
    logic [NUM_BYTES-1:0] req_be;
    logic [DATA_W-1:0] req_wdata;
    logic              ack;
    logic              ack_corrected;
    logic              ack_uncorrectable;
    logic              mem_en;
    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [CODE_W-1:0] mem_wdata;
    logic [CODE_W-1:0] mem_rdata;

    logic [CODE_W-1:0] mem [DEPTH];
    int rd_cnt = 0;
    int wr_cnt = 0;
    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;
    int pos_tab [DATA_W];

    always #(CLK_PERIOD/2) clk = ~clk;

    subword_rmw #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .init_done(init_done),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .ack(ack), .ack_corrected(ack_corrected), .ack_uncorrectable(ack_uncorrectable),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent SEC-DED validity test in Hamming position space.
    function automatic bit code_valid(input logic [CODE_W-1:0] c);
        int x;
        x = 0;
        for (int i = 0; i < DATA_W; i++) if (c[i]) x = x ^ pos_tab[i];
        for (int j = 0; j < HAM_W; j++) if (c[DATA_W+j]) x = x ^ (1 << j);
        return (x == 0) && ((^c) == 1'b0);
    endfunction

    function automatic logic [31:0] expect_merge(input logic [31:0] oldd, input logic [31:0] newd,
                                                 input logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? newd[b*8 +: 8] : oldd[b*8 +: 8];
        return r;
    endfunction

    task automatic do_write(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d,
                            output int lat, output int nrd, output int nwr,
                            output bit fc, output bit fu);
        int r0;
        int w0;
        r0 = rd_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_be    = be;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        lat = 0;
        do begin
            @(posedge clk);
            #1;
            lat++;
        end while (!ack && lat < 20);
        fc  = ack_corrected;
        fu  = ack_uncorrectable;
        nrd = rd_cnt - r0;
        nwr = wr_cnt - w0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int n;
        int lat, nrd, nwr;
        bit fc, fu;
        logic [31:0] base, nd, oldd, exp_d;
        logic [3:0] be;
        logic [AW-1:0] a;

        n = 0;
        for (int q = 3; q < 64; q++) begin
            if ((q & (q - 1)) != 0 && n < DATA_W) begin
                pos_tab[n] = q;
                n++;
            end
        end

        rst = 1'b1; init_done = 1'b0; req_valid = 1'b0;
        req_addr = '0; req_be = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(req_ready == 0, "R1 ready after reset", 64'(req_ready), 0);
        check(ack == 0, "R1 ack after reset", 64'(ack), 0);
        check(mem_en == 0, "R1 mem_en after reset", 64'(mem_en), 0);

        // R1: request held while memory not initialised
        req_valid = 1'b1; req_be = 4'hF; req_wdata = 32'h1234_5678;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(req_ready == 0 && mem_en == 0, "R1 blocked before init",
                  64'({req_ready, mem_en}), 0);
        end
        check(wr_cnt == 0 && rd_cnt == 0, "R1 no access before init", 64'(wr_cnt + rd_cnt), 0);
        req_valid = 1'b0;
        init_done = 1'b1;

        // Full-word writes: R2 no read, R4 valid code, R7 latency 2, flags clear
        for (int i = 0; i < DEPTH; i++) begin
            base = 32'h9E37_79B9 * (i + 1) ^ 32'h0F0F_5A5A;
            do_write(AW'(i), 4'hF, base, lat, nrd, nwr, fc, fu);
            check(nrd == 0 && nwr == 1, "R2 full write no read", 64'({nrd[7:0], nwr[7:0]}), 64'h0001);
            check(lat == 2, "R7 full latency", 64'(lat), 2);
            check(mem[i][31:0] == base, "R3 full data", 64'(mem[i][31:0]), 64'(base));
            check(code_valid(mem[i]), "R4 full codeword", 64'(mem[i]), 1);
            check(!fc && !fu, "R7 full flags", 64'({fc, fu}), 0);
        end

        // Partial writes on clean words: every non-full enable pattern
        for (int e = 0; e < 15; e++) begin
            be = 4'(e);
            a  = AW'(e);
            oldd = mem[a][31:0];
            nd = ~oldd ^ (32'h0101_0101 * (e + 3));
            do_write(a, be, nd, lat, nrd, nwr, fc, fu);
            exp_d = expect_merge(oldd, nd, be);
            check(nrd == 1 && nwr == 1, "R2 partial read+write", 64'({nrd[7:0], nwr[7:0]}), 64'h0101);
            check(lat == 3, "R7 partial latency", 64'(lat), 3);
            check(mem[a][31:0] == exp_d, "R3 merged lanes", 64'(mem[a][31:0]), 64'(exp_d));
            check(code_valid(mem[a]), "R4 partial codeword", 64'(mem[a]), 1);
            check(!fc && !fu, "R7 clean flags", 64'({fc, fu}), 0);
        end

        // R5: single-bit fault at every one of the 39 positions
        for (int bitn = 0; bitn < CODE_W; bitn++) begin
            a  = AW'(bitn % DEPTH);
            be = 4'(bitn % 15);
            base = 32'hC3A5_1E7D + 32'(bitn * 32'h0011_2233);
            do_write(a, 4'hF, base, lat, nrd, nwr, fc, fu);
            @(negedge clk);
            mem[a][bitn] = ~mem[a][bitn];
            nd = 32'hDEAD_BEEF ^ 32'(bitn);
            do_write(a, be, nd, lat, nrd, nwr, fc, fu);
            exp_d = expect_merge(base, nd, be);
            check(mem[a][31:0] == exp_d, "R5 repaired merge", 64'(mem[a][31:0]), 64'(exp_d));
            check(code_valid(mem[a]), "R5 repaired codeword", 64'(mem[a]), 1);
            check(fc && !fu, "R5 flags", 64'({fc, fu}), 64'h2);
        end

        // R6: double-bit faults, write still completes with unrepaired old lanes
        for (int k = 0; k < 24; k++) begin
            int b0, b1;
            b0 = k;
            b1 = (k * 7 + 3) % CODE_W;
            if (b1 == b0) b1 = (b1 + 1) % CODE_W;
            a  = AW'(k % DEPTH);
            be = 4'((k % 14) + 1);
            base = 32'h5555_AAAA ^ 32'(k * 32'h0100_0081);
            do_write(a, 4'hF, base, lat, nrd, nwr, fc, fu);
            @(negedge clk);
            mem[a][b0] = ~mem[a][b0];
            mem[a][b1] = ~mem[a][b1];
            oldd = mem[a][31:0];
            nd = 32'h0BAD_F00D + 32'(k);
            do_write(a, be, nd, lat, nrd, nwr, fc, fu);
            exp_d = expect_merge(oldd, nd, be);
            check(lat == 3 && nwr == 1, "R6 write completes", 64'({lat[7:0], nwr[7:0]}), 64'h0301);
            check(mem[a][31:0] == exp_d, "R6 raw merge", 64'(mem[a][31:0]), 64'(exp_d));
            check(code_valid(mem[a]), "R6 re-encoded", 64'(mem[a]), 1);
            check(!fc && fu, "R6 flags", 64'({fc, fu}), 64'h1);
        end

        @(negedge clk);
        check(ack == 0, "R7 ack returns low", 64'(ack), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule